// File: doc/BRIEF.md
# SMBus Alert Response Target

This block sits beside a sensor that signals events on a shared open-drain interrupt line. When several such sensors share that line, the bus controller broadcasts a read to the SMBus alert response address to find out who raised it. This block watches SCL and SDA and tracks START and STOP conditions. When the sensor is in latched window-comparator mode and has an interrupt pending, the block acknowledges that broadcast read. It then returns a byte made of its own 7-bit address with the live high-threshold flag in the least-significant bit.

Responding targets compete bit by bit on the wired-AND data line, so the lowest byte wins. A target that sees the line low while it is letting go for a 1 has lost. It goes quiet until the next START or STOP and keeps its interrupt active, so a later broadcast can pick it up. The winner lets go of SDA for the controller's acknowledge bit and, on the rising SCL edge of that ninth clock, asks the sensor to release its interrupt pin. The block has no path to the sensor's threshold flags, so they are left as they were. Normal register traffic, clock stretching and high-speed signalling are handled elsewhere.

The controller FSM has seven states. ST_IDLE waits for START. ST_ADDR shifts in the address byte. ST_ACK_DRIVE waits for SCL low before pulling the acknowledge. ST_ACK_HOLD holds the acknowledge through the ninth clock. ST_SEND shifts out the reply and arbitrates. ST_HOSTACK leaves SDA free for the controller's acknowledge bit. ST_WAIT stays silent until the bus frees.

The transitions are:
- START from any state leads to ST_ADDR, and STOP from any state leads to ST_IDLE.
- In ST_ADDR, the eighth SCL rise leads to ST_ACK_DRIVE on a match, otherwise to ST_WAIT.
- Each SCL fall moves ST_ACK_DRIVE to ST_ACK_HOLD, and then ST_ACK_HOLD to ST_SEND.
- In ST_SEND, lost arbitration on a rise leads to ST_WAIT. The fall after the eighth reply bit leads to ST_HOSTACK.
- In ST_HOSTACK, the next SCL rise leads to ST_WAIT.

Top module: `alert_resp_target`

## Requirements
- R1: After reset, `sda_pd_o` and `irq_release_o` are both 0.
- R2: With `latched_mode_i`=1 and `irq_pending_i`=1, an address byte of 8'h19 (7'b0001100 plus read bit 1, sent MSB first) is acknowledged by driving `sda_pd_o`=1 through the ninth SCL clock.
- R3: With `latched_mode_i`=0, the block never drives SDA and never requests a release.
- R4: With `irq_pending_i`=0, the block never drives SDA and never requests a release.
- R5: Any other address byte, including 8'h18 (the alert address with the write bit), is ignored with no acknowledge.
- R6: After the acknowledge, the reply is sent MSB first. It is `DEV_ADDR` followed by the value of `hi_flag_i` captured on the eighth address bit, which goes in the LSB.
- R7: A reply bit of 1 that reads back as 0 on SCL rise means lost arbitration. The block drives nothing further in that transaction and does not request a release.
- R8: A winner releases SDA after the eighth reply bit. It pulses `irq_release_o` for exactly one clock on the ninth SCL rise.
- R9: `sda_pd_o` changes only while SCL is low.
- R10: START or STOP at any point aborts the transaction and releases SDA. After a STOP the block answers again while still armed.
- R11: With two targets armed, the lower address wins and the loser keeps its interrupt. A following alert read is answered by the loser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND) |
| latched_mode_i | input | 1 | 1 when the comparator is in latched window mode |
| irq_pending_i | input | 1 | 1 while the sensor holds its interrupt active |
| hi_flag_i | input | 1 | Current high-threshold flag |
| sda_pd_o | output | 1 | Pull SDA low when 1 |
| irq_release_o | output | 1 | One-clock request to deassert the interrupt pin |

## Verification
The assertions assume that the mode and pending inputs only change while the bus is idle. They also assume a well-formed bus: SDA changes only while SCL is low, except for START and STOP. The stimulus respects both. Every master action is a whole START-to-STOP sequence, and mode, pending and flag inputs are set only between transactions. The one exception is a master that aborts with START or STOP, and it only does so while no target is driving. Two instances with different addresses share one modelled open-drain line, so arbitration is exercised through real wired-AND feedback.

// File: rtl/alert_pkg.sv
package alert_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_DRIVE,
        ST_ACK_HOLD,
        ST_SEND,
        ST_HOSTACK,
        ST_WAIT
    } ara_state_e;
endpackage

// File: rtl/ara_bus_sense.sv
module ara_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    // data edges while the clock stays high
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ara_resp_fsm.sv
module ara_resp_fsm
    import alert_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start_det,
    input  logic stop_det,
    input  logic sda_i,
    input  logic armed_i,
    input  logic hi_flag_i,
    output logic sda_pd_o,
    output logic irq_release_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int MSB   = BYTE_W - 1;

    ara_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q, resp_q;
    logic [BYTE_W-1:0] addr_byte;
    logic              last_bit, addr_hit, done, lost;

    assign addr_byte = {sh_q[BYTE_W-2:0], sda_i};
    assign last_bit  = (cnt_q == CNT_W'(BYTE_W - 1));
    assign done      = (cnt_q == CNT_W'(BYTE_W));
    assign addr_hit  = armed_i && (addr_byte == {ARA_ADDR, 1'b1});
    assign lost      = scl_rise && resp_q[MSB] && !sda_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (scl_rise && last_bit)
                                  state_d = addr_hit ? ST_ACK_DRIVE : ST_WAIT;
                ST_ACK_DRIVE: if (scl_fall) state_d = ST_ACK_HOLD;
                ST_ACK_HOLD:  if (scl_fall) state_d = ST_SEND;
                ST_SEND:      if (lost) state_d = ST_WAIT;
                              else if (scl_fall && done) state_d = ST_HOSTACK;
                ST_HOSTACK:   if (scl_rise) state_d = ST_WAIT;
                ST_WAIT:      state_d = ST_WAIT;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register and bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            resp_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_det) begin
                cnt_q <= '0;
            end else if (!stop_det) begin
                unique case (state_q)
                    ST_ADDR: if (scl_rise) begin
                        sh_q  <= addr_byte;
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (last_bit) resp_q <= {DEV_ADDR, hi_flag_i};
                    end
                    ST_ACK_HOLD: if (scl_fall) cnt_q <= '0;
                    ST_SEND: begin
                        if (scl_rise) cnt_q <= cnt_q + CNT_W'(1);
                        if (scl_fall && !done) resp_q <= resp_q << 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // output register: SDA moves only on SCL fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pd_o      <= 1'b0;
            irq_release_o <= 1'b0;
        end else begin
            irq_release_o <= 1'b0;
            if (start_det || stop_det) begin
                sda_pd_o <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ACK_DRIVE: if (scl_fall) sda_pd_o <= 1'b1;
                    ST_ACK_HOLD:  if (scl_fall) sda_pd_o <= ~resp_q[MSB];
                    ST_SEND:      if (scl_fall) sda_pd_o <= done ? 1'b0 : ~resp_q[MSB-1];
                    ST_HOSTACK: begin
                        sda_pd_o <= 1'b0;
                        if (scl_rise) irq_release_o <= 1'b1;
                    end
                    default:      sda_pd_o <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/alert_resp_target.sv
module alert_resp_target
    import alert_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic latched_mode_i,
    input  logic irq_pending_i,
    input  logic hi_flag_i,
    output logic sda_pd_o,
    output logic irq_release_o
);
    logic scl_rise, scl_fall, start_det, stop_det;
    logic armed;

    assign armed = latched_mode_i & irq_pending_i;

    ara_bus_sense u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ara_resp_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .sda_i         (sda_i),
        .armed_i       (armed),
        .hi_flag_i     (hi_flag_i),
        .sda_pd_o      (sda_pd_o),
        .irq_release_o (irq_release_o)
    );
endmodule

// File: rtl/alert_resp_chk.sv
module alert_resp_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic latched_mode_i,
    input logic irq_pending_i,
    input logic sda_pd_o,
    input logic irq_release_o
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pd_o != $past(sda_pd_o)) |-> !$past(scl_i)); // R9

    AST_SILENT_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        !latched_mode_i |-> (!sda_pd_o && !irq_release_o)); // R3

    AST_SILENT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending_i |-> (!sda_pd_o && !irq_release_o)); // R4

    AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_release_o |=> !irq_release_o); // R8

    AST_RELEASE_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_release_o |-> (!sda_pd_o && $past(scl_i))); // R8

    AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pd_o); // R10
endmodule

bind alert_resp_target alert_resp_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl_i),
    .sda_i          (sda_i),
    .latched_mode_i (latched_mode_i),
    .irq_pending_i  (irq_pending_i),
    .sda_pd_o       (sda_pd_o),
    .irq_release_o  (irq_release_o)
);

// File: tb/tb_alert_resp_target.sv
module tb_alert_resp_target;
    localparam int Q = 4;
    localparam int NV = 10;
    // {modeA,pendA,modeB,pendB,hiA,hiB}, addr byte, ack, reply, relA, relB
    localparam logic [24:0] VECS [NV] = '{
        {6'b110000, 8'h19, 1'b1, 8'h90, 2'b10},
        {6'b110010, 8'h19, 1'b1, 8'h91, 2'b10},
        {6'b010000, 8'h19, 1'b0, 8'h00, 2'b00},
        {6'b101000, 8'h19, 1'b0, 8'h00, 2'b00},
        {6'b111100, 8'h18, 1'b0, 8'h00, 2'b00},
        {6'b111100, 8'h91, 1'b0, 8'h00, 2'b00},
        {6'b111110, 8'h19, 1'b1, 8'h91, 2'b10},
        {6'b001101, 8'h19, 1'b1, 8'h95, 2'b01},
        {6'b110100, 8'h19, 1'b1, 8'h90, 2'b10},
        {6'b101111, 8'h19, 1'b1, 8'h95, 2'b01}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic scl = 1'b1, m_pd = 1'b0;
    logic mode_a = 0, pend_a = 0, hi_a = 0, mode_b = 0, pend_b = 0, hi_b = 0;
    logic pd_a, pd_b, rel_a, rel_b, sda;
    assign sda = !(m_pd | pd_a | pd_b);

    int n_chk = 0, n_bad = 0;
    int rel_cnt_a = 0, rel_cnt_b = 0, hi_moves = 0;
    logic pa_s = 0, pb_s = 0, scl_s = 1;

    alert_resp_target #(.DEV_ADDR(7'h48)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .latched_mode_i(mode_a), .irq_pending_i(pend_a), .hi_flag_i(hi_a),
        .sda_pd_o(pd_a), .irq_release_o(rel_a));

    alert_resp_target #(.DEV_ADDR(7'h4A)) dut_b (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .latched_mode_i(mode_b), .irq_pending_i(pend_b), .hi_flag_i(hi_b),
        .sda_pd_o(pd_b), .irq_release_o(rel_b));

    always @(posedge clk) begin
        if (rel_a) rel_cnt_a++;
        if (rel_b) rel_cnt_b++;
        if (((pd_a != pa_s) || (pd_b != pb_s)) && scl_s) hi_moves++;
        pa_s = pd_a;
        pb_s = pd_b;
        scl_s = scl;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_pd = 0; wq(Q); scl = 1; wq(Q); m_pd = 1; wq(Q); scl = 0;
    endtask

    task automatic bus_stop;
        m_pd = 1; wq(Q); scl = 1; wq(Q); m_pd = 0; wq(Q);
    endtask

    task automatic wr_bit(input logic b);
        m_pd = !b; wq(Q); scl = 1; wq(Q); scl = 0;
    endtask

    task automatic rd_bit(output logic b);
        m_pd = 0; wq(Q); scl = 1; wq(Q); b = sda; scl = 0;
    endtask

    task automatic run_ara(input logic [7:0] abyte, output logic ack, output logic [7:0] data);
        logic b;
        bus_start;
        for (int i = 7; i >= 0; i--) wr_bit(abyte[i]);
        rd_bit(b);
        ack = !b;
        data = '0;
        if (ack) begin
            for (int i = 0; i < 8; i++) begin
                rd_bit(b);
                data = {data[6:0], b};
            end
            wr_bit(1'b1);
        end
        bus_stop;
        wq(Q);
    endtask

    function automatic string vtag(input int k);
        case (k)
            0: return "R2 R8 single winner";
            1: return "R6 flag in LSB";
            2: return "R3 transparent mode";
            3: return "R4 nothing pending";
            4: return "R5 write bit";
            5: return "R5 foreign address";
            6: return "R7 arbitration loss";
            7: return "R6 second device";
            8: return "R3 peer transparent";
            9: return "R4 peer idle";
            default: return "vector";
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic ack;
        logic [7:0] data;
        int ra, rb;
        wq(3);
        chk("R1 pd during reset", pd_a, 0);
        rst_n = 1;
        wq(3);
        chk("R1 pd after reset", pd_a | pd_b, 0);
        chk("R1 release after reset", rel_a | rel_b, 0);

        for (int k = 0; k < NV; k++) begin
            logic [24:0] v;
            v = VECS[k];
            {mode_a, pend_a, mode_b, pend_b, hi_a, hi_b} = v[24:19];
            wq(2);
            ra = rel_cnt_a; rb = rel_cnt_b;
            run_ara(v[18:11], ack, data);
            chk({vtag(k), " ack"}, ack, v[10]);
            if (v[10]) chk({vtag(k), " reply"}, data, v[9:2]);
            chk({vtag(k), " releaseA"}, rel_cnt_a - ra, v[1]);
            chk({vtag(k), " releaseB"}, rel_cnt_b - rb, v[0]);
            chk({vtag(k), " sda free"}, pd_a | pd_b, 0);
        end

        // R11: lower address wins, loser answers the next broadcast
        {mode_a, pend_a, mode_b, pend_b, hi_a, hi_b} = 6'b111100;
        wq(2);
        ra = rel_cnt_a; rb = rel_cnt_b;
        run_ara(8'h19, ack, data);
        chk("R11 first reply", data, 8'h90);
        chk("R11 loser keeps irq", rel_cnt_b - rb, 0);
        chk("R11 winner released", rel_cnt_a - ra, 1);
        pend_a = 0;
        wq(2);
        run_ara(8'h19, ack, data);
        chk("R11 second ack", ack, 1);
        chk("R11 second reply", data, 8'h94);
        chk("R11 loser released", rel_cnt_b - rb, 1);
        pend_b = 0;
        wq(2);
        run_ara(8'h19, ack, data);
        chk("R4 all cleared no ack", ack, 0);

        // R10: repeated START inside the address byte
        {mode_a, pend_a, mode_b, pend_b, hi_a, hi_b} = 6'b110000;
        wq(2);
        ra = rel_cnt_a;
        bus_start;
        wr_bit(0); wr_bit(0); wr_bit(0); wr_bit(1);
        run_ara(8'h19, ack, data);
        chk("R10 restart ack", ack, 1);
        chk("R10 restart reply", data, 8'h90);
        // R10: STOP inside the address byte, then re-arm and repeat
        bus_start;
        wr_bit(0); wr_bit(0); wr_bit(0);
        bus_stop;
        chk("R10 stop frees sda", pd_a, 0);
        run_ara(8'h19, ack, data);
        chk("R10 rearmed after stop", ack, 1);
        chk("R10 repeat releases", rel_cnt_a - ra, 2);

        chk("R9 sda moved with scl high", hi_moves, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule